// File: doc/BRIEF.md
# CAN Freeze-Mode Entry Controller

This block moves a CAN controller into a frozen state and brings it back out. A freeze is requested when software sets its halt bit or the chip enters debug mode, and only while the freeze-enable bit is set. The block does not freeze straight away. It first waits for the protocol engine to report a state in which stopping is harmless (intermission, error-passive, bus-off or idle). It also waits until no message-buffer move is in progress. Only when both conditions hold in the same cycle does it isolate the bus, stop the bit-rate prescaler, open the error counter register for writes and raise its not-ready and acknowledge flags.

The block sits between the CAN pins and the protocol engine. The engine's transmit bit passes through it to the pin, and the pin's receive bit passes through it to the engine. Both paths are registered, so each adds one cycle. While frozen, both paths are held at the recessive level. When the request goes away, the block returns to normal operation on the next clock edge. A request that is withdrawn before the safe point is reached leaves every freeze output untouched.

Top module: `frz_ctrl`

## Requirements
- R1: After synchronous reset, presc_stop, rx_ignore, tx_force_rec, ecr_wr_en, not_ready and frz_ack are 0, and can_tx and eng_rx are 1 (recessive).
- R2: A freeze request exists only when (halt_req OR dbg_mode) AND frz_en. With frz_en at 0, or with both halt_req and dbg_mode at 0, no freeze output is ever asserted.
- R3: When a request is present, at least one safe-state input is 1 and move_busy is 0, the freeze outputs are still 0 after the first clock edge that sees the request and are 1 after the second.
- R4: While none of st_intermission, st_err_passive, st_bus_off and st_idle is 1, the block does not freeze.
- R5: While move_busy is 1, the block does not freeze, whatever the safe-state inputs are.
- R6: Any single one of the four safe-state inputs is enough to allow entry.
- R7: While frozen, can_tx is 1 whatever eng_tx is, and eng_rx is 1 whatever can_rx is.
- R8: While not frozen, can_tx equals eng_tx and eng_rx equals can_rx, each delayed by one clock edge.
- R9: presc_stop, rx_ignore, tx_force_rec, ecr_wr_en, not_ready and frz_ack always carry the same value, so the error counter is writable exactly while the block is frozen.
- R10: If the request is absent at a clock edge, every freeze output is 0 after that edge.
- R11: If the request is withdrawn while the block is waiting for the safe point, the block returns to normal operation without asserting any freeze output, even when the bus later becomes safe.
- R12: Once frozen, the block stays frozen as long as the request holds, whatever the safe-state inputs and move_busy do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Software halt bit |
| dbg_mode | input | 1 | Chip is in debug mode |
| frz_en | input | 1 | Freeze enable; when 0, requests are ignored |
| st_intermission | input | 1 | Protocol engine is in intermission |
| st_err_passive | input | 1 | Protocol engine is error-passive |
| st_bus_off | input | 1 | Protocol engine is bus-off |
| st_idle | input | 1 | Protocol engine is idle |
| move_busy | input | 1 | A buffer move-in or move-out is in progress |
| eng_tx | input | 1 | Transmit bit from the protocol engine |
| can_rx | input | 1 | Receive bit from the CAN pin |
| presc_stop | output | 1 | Stops the bit-rate prescaler |
| rx_ignore | output | 1 | Receive input is being ignored |
| tx_force_rec | output | 1 | Transmit line is forced recessive |
| ecr_wr_en | output | 1 | Write enable for the error counter register |
| not_ready | output | 1 | Controller is not ready |
| frz_ack | output | 1 | Freeze acknowledge |
| can_tx | output | 1 | Transmit bit to the CAN pin |
| eng_rx | output | 1 | Receive bit to the protocol engine |

## Verification
The hardest situation to reach is a withdrawal in the middle of the wait: the block has accepted a request but is still held off by an unsafe bus or a busy move, and the request disappears before the safe point arrives. The stimulus raises the halt bit with every safe-state input at 0 and waits two edges. It then drops the halt bit, makes the bus safe and watches several more cycles, expecting no freeze output. A second path holds move_busy high with a safe bus, then withdraws freeze-enable instead of halt. The main sweep covers all 256 combinations of the three request inputs, the four safe-state inputs and the busy flag.

// File: rtl/frz_pkg.sv
package frz_pkg;

    localparam int  SAFE_W    = 4;
    localparam logic RECESSIVE = 1'b1;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_WAIT_SAFE = 2'd1,
        ST_FROZEN    = 2'd2
    } frz_state_e;

    typedef struct packed {
        logic presc_stop;
        logic rx_ignore;
        logic tx_force_rec;
        logic ecr_wr_en;
        logic not_ready;
        logic frz_ack;
    } frz_flags_t;

    localparam frz_flags_t FLAGS_OFF = '0;

    function automatic frz_flags_t flags_for(frz_state_e s);
        frz_flags_t f;
        f = FLAGS_OFF;
        if (s == ST_FROZEN) begin
            f.presc_stop   = 1'b1;
            f.rx_ignore    = 1'b1;
            f.tx_force_rec = 1'b1;
            f.ecr_wr_en    = 1'b1;
            f.not_ready    = 1'b1;
            f.frz_ack      = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/frz_cond.sv
module frz_cond
    import frz_pkg::*;
(
    input  logic              halt_req,
    input  logic              dbg_mode,
    input  logic              frz_en,
    input  logic [SAFE_W-1:0] safe_vec,
    input  logic              move_busy,
    output logic              req,
    output logic              entry_ok
);
    logic bus_safe;

    always_comb begin
        req      = (halt_req | dbg_mode) & frz_en;
        bus_safe = |safe_vec;
        entry_ok = bus_safe & ~move_busy;
    end
endmodule

// File: rtl/frz_fsm.sv
module frz_fsm
    import frz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       entry_ok,
    output frz_state_e state_d
);
    frz_state_e state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (req) state_d = ST_WAIT_SAFE;
            ST_WAIT_SAFE: begin
                if (!req)          state_d = ST_RUN;
                else if (entry_ok) state_d = ST_FROZEN;
            end
            ST_FROZEN:    if (!req) state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/frz_out_reg.sv
module frz_out_reg
    import frz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frz_state_e state_d,
    input  logic       eng_tx,
    input  logic       can_rx,
    output frz_flags_t flags_q,
    output logic       can_tx_q,
    output logic       eng_rx_q
);
    frz_flags_t flags_d;

    always_comb flags_d = flags_for(state_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= FLAGS_OFF;
            can_tx_q <= RECESSIVE;
            eng_rx_q <= RECESSIVE;
        end else begin
            flags_q  <= flags_d;
            can_tx_q <= flags_d.tx_force_rec ? RECESSIVE : eng_tx;
            eng_rx_q <= flags_d.rx_ignore    ? RECESSIVE : can_rx;
        end
    end
endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl
    import frz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic dbg_mode,
    input  logic frz_en,
    input  logic st_intermission,
    input  logic st_err_passive,
    input  logic st_bus_off,
    input  logic st_idle,
    input  logic move_busy,
    input  logic eng_tx,
    input  logic can_rx,
    output logic presc_stop,
    output logic rx_ignore,
    output logic tx_force_rec,
    output logic ecr_wr_en,
    output logic not_ready,
    output logic frz_ack,
    output logic can_tx,
    output logic eng_rx
);
    logic [SAFE_W-1:0] safe_vec;
    logic              req;
    logic              entry_ok;
    frz_state_e        state_d;
    frz_flags_t        flags_q;

    assign safe_vec = {st_idle, st_bus_off, st_err_passive, st_intermission};

    frz_cond u_cond (
        .halt_req  (halt_req),
        .dbg_mode  (dbg_mode),
        .frz_en    (frz_en),
        .safe_vec  (safe_vec),
        .move_busy (move_busy),
        .req       (req),
        .entry_ok  (entry_ok)
    );

    frz_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .entry_ok (entry_ok),
        .state_d  (state_d)
    );

    frz_out_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .state_d  (state_d),
        .eng_tx   (eng_tx),
        .can_rx   (can_rx),
        .flags_q  (flags_q),
        .can_tx_q (can_tx),
        .eng_rx_q (eng_rx)
    );

    assign presc_stop   = flags_q.presc_stop;
    assign rx_ignore    = flags_q.rx_ignore;
    assign tx_force_rec = flags_q.tx_force_rec;
    assign ecr_wr_en    = flags_q.ecr_wr_en;
    assign not_ready    = flags_q.not_ready;
    assign frz_ack      = flags_q.frz_ack;
endmodule

// File: rtl/frz_ctrl_chk.sv
module frz_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic halt_req,
    input logic dbg_mode,
    input logic frz_en,
    input logic st_intermission,
    input logic st_err_passive,
    input logic st_bus_off,
    input logic st_idle,
    input logic move_busy,
    input logic presc_stop,
    input logic rx_ignore,
    input logic tx_force_rec,
    input logic ecr_wr_en,
    input logic not_ready,
    input logic frz_ack,
    input logic can_tx,
    input logic eng_rx
);
    logic want;
    logic safe_ok;

    always_comb begin
        want    = (halt_req | dbg_mode) & frz_en;
        safe_ok = (st_intermission | st_err_passive | st_bus_off | st_idle) & ~move_busy;
    end

    AST_DROP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !want |=> !frz_ack && !ecr_wr_en && !presc_stop); // R10

    AST_ENTRY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(frz_ack) |-> $past(want)); // R2

    AST_ENTRY_NEEDS_SAFE: assert property (@(posedge clk) disable iff (rst)
        $rose(frz_ack) |-> $past(safe_ok)); // R4

    AST_TX_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        frz_ack |-> can_tx && eng_rx); // R7

    AST_FLAGS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (ecr_wr_en == frz_ack) && (presc_stop == frz_ack) && (not_ready == frz_ack)
        && (rx_ignore == frz_ack) && (tx_force_rec == frz_ack)); // R9

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        frz_ack && want |=> frz_ack); // R12
endmodule

bind frz_ctrl frz_ctrl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .halt_req        (halt_req),
    .dbg_mode        (dbg_mode),
    .frz_en          (frz_en),
    .st_intermission (st_intermission),
    .st_err_passive  (st_err_passive),
    .st_bus_off      (st_bus_off),
    .st_idle         (st_idle),
    .move_busy       (move_busy),
    .presc_stop      (presc_stop),
    .rx_ignore       (rx_ignore),
    .tx_force_rec    (tx_force_rec),
    .ecr_wr_en       (ecr_wr_en),
    .not_ready       (not_ready),
    .frz_ack         (frz_ack),
    .can_tx          (can_tx),
    .eng_rx          (eng_rx)
);

// File: tb/tb_frz_ctrl.sv
`timescale 1ns/1ps
module tb_frz_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 0, dbg_mode = 0, frz_en = 0;
    logic st_intermission = 0, st_err_passive = 0, st_bus_off = 0, st_idle = 0;
    logic move_busy = 0, eng_tx = 1, can_rx = 1;
    logic presc_stop, rx_ignore, tx_force_rec, ecr_wr_en, not_ready, frz_ack, can_tx, eng_rx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    frz_ctrl dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .dbg_mode(dbg_mode), .frz_en(frz_en),
        .st_intermission(st_intermission), .st_err_passive(st_err_passive),
        .st_bus_off(st_bus_off), .st_idle(st_idle), .move_busy(move_busy),
        .eng_tx(eng_tx), .can_rx(can_rx), .presc_stop(presc_stop), .rx_ignore(rx_ignore),
        .tx_force_rec(tx_force_rec), .ecr_wr_en(ecr_wr_en), .not_ready(not_ready),
        .frz_ack(frz_ack), .can_tx(can_tx), .eng_rx(eng_rx)
    );

    function automatic logic [5:0] flags();
        return {presc_stop, rx_ignore, tx_force_rec, ecr_wr_en, not_ready, frz_ack};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_safe(logic [3:0] v);
        {st_idle, st_bus_off, st_err_passive, st_intermission} = v;
    endtask

    task automatic do_reset();
        halt_req = 0; dbg_mode = 0; frz_en = 0; move_busy = 0;
        set_safe(4'b0); eng_tx = 1; can_rx = 1;
        rst = 1;
        step(2);
        rst = 0;
    endtask

    initial begin
        #700000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset values
        chk("R1 flags", {2'b0, flags()}, 8'h00);
        chk("R1 tx/rx", {6'b0, can_tx, eng_rx}, 8'h03);

        // Exhaustive sweep: request inputs x safe inputs x busy
        for (int r = 0; r < 8; r++) begin
            for (int s = 0; s < 16; s++) begin
                for (int b = 0; b < 2; b++) begin
                    logic rq, expf;
                    do_reset();
                    {halt_req, dbg_mode, frz_en} = r[2:0];
                    set_safe(s[3:0]);
                    move_busy = b[0];
                    rq   = (r[2] | r[1]) & r[0];
                    expf = rq && (s != 0) && (b == 0); // R2 R4 R5 R6
                    step(1);
                    chk("R3 not after first edge", {2'b0, flags()}, 8'h00);
                    step(1);
                    chk(!rq ? "R2" : (s == 0) ? "R4" : b ? "R5" : "R6",
                        {2'b0, flags()}, expf ? 8'h3F : 8'h00); // R9 all flags together
                    step(2);
                    chk("R3 settled", {7'b0, frz_ack}, {7'b0, expf});
                end
            end
        end

        // R8: pass-through when not frozen, one-edge delay
        do_reset();
        for (int v = 0; v < 4; v++) begin
            eng_tx = v[0]; can_rx = v[1];
            step(1);
            chk("R8 pass", {6'b0, can_tx, eng_rx}, {6'b0, v[0], v[1]});
        end

        // R7 / R12: frozen then bus goes unsafe and busy
        do_reset();
        halt_req = 1; frz_en = 1; st_idle = 1;
        step(2);
        chk("R3 frozen", {2'b0, flags()}, 8'h3F);
        eng_tx = 0; can_rx = 0;
        step(1);
        chk("R7 recessive", {6'b0, can_tx, eng_rx}, 8'h03);
        set_safe(4'b0); move_busy = 1;
        step(3);
        chk("R12 hold", {2'b0, flags()}, 8'h3F);
        chk("R7 still recessive", {6'b0, can_tx, eng_rx}, 8'h03);
        // R10: halt removed -> leave on next edge
        halt_req = 0;
        step(1);
        chk("R10 release", {2'b0, flags()}, 8'h00);
        chk("R8 pass after release", {6'b0, can_tx, eng_rx}, 8'h00);

        // R10 via frz_en drop while in debug mode
        do_reset();
        dbg_mode = 1; frz_en = 1; st_bus_off = 1;
        step(2);
        chk("R3 debug freeze", {7'b0, frz_ack}, 8'h01);
        frz_en = 0;
        step(1);
        chk("R10 enable drop", {2'b0, flags()}, 8'h00);

        // R11: withdrawn during wait (unsafe bus)
        do_reset();
        halt_req = 1; frz_en = 1;
        step(2);
        chk("R11 waiting", {7'b0, frz_ack}, 8'h00);
        halt_req = 0;
        step(1);
        set_safe(4'b1111);
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R11 no freeze", {2'b0, flags()}, 8'h00);
        end

        // R11: withdrawn during wait (busy move) via enable
        do_reset();
        halt_req = 1; frz_en = 1; st_err_passive = 1; move_busy = 1;
        step(3);
        chk("R5 busy wait", {7'b0, frz_ack}, 8'h00);
        frz_en = 0;
        step(1);
        move_busy = 0;
        step(3);
        chk("R11 enable withdrawn", {2'b0, flags()}, 8'h00);
        // re-request: freeze follows in two edges from RUN
        frz_en = 1;
        step(1);
        chk("R3 re-request first edge", {7'b0, frz_ack}, 8'h00);
        step(1);
        chk("R3 re-request second edge", {7'b0, frz_ack}, 8'h01);

        // R5: busy clears late -> freeze one edge after
        do_reset();
        halt_req = 1; frz_en = 1; st_intermission = 1; move_busy = 1;
        step(4);
        chk("R5 held", {7'b0, frz_ack}, 8'h00);
        move_busy = 0;
        step(1);
        chk("R5 drained", {2'b0, flags()}, 8'h3F);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule